// File: doc/BRIEF.md
# Correlated Multi-Sample Charge Extractor

This block sits behind the ADC of one photodetector channel. The analogue front end is a charge integrator that leaks slowly. A detector pulse shows up in its output as a step with a fast, controlled edge. The block receives the digitised integrator output as an unbroken stream of unsigned samples. Each sample is flagged by a strobe, and new samples arrive at twice the basic sampling rate.

For every accepted sample, the block treats the newest samples as the "after" window. It skips a configurable guard gap that covers the rise of the step, and treats the next older samples as the "before" window. It sums each window and returns after-minus-before as a signed amplitude with a valid strobe. Averaging four samples on each side lowers the noise compared with a single pair. The scale factor of four is left in the result.

The integrator is cleared at regular intervals. A pulse on the integrator-reset input restarts the block's count of usable samples. No amplitude is flagged valid while either window still holds a sample taken before that clear.

Top module: `cms_charge_extract`

## Requirements
- R1: While rst_ni is low, amp_valid_o is 0 and amp_o is 0.
- R2: A cycle with sample_valid_i low neither shifts the sample history nor produces an amp_valid_o strobe two edges later.
- R3: With the guard gap at 0, a valid result equals the sum of the four newest accepted samples minus the sum of the four accepted samples just older than those. It is written as 15-bit two's complement.
- R4: gap_i (unsigned, 0 to 7) is the number of accepted samples skipped between the two windows. The older window starts at the (5 + gap_i)-th newest sample.
- R5: Each accepted sample yields exactly one result. The result appears on amp_o/amp_valid_o after the second rising edge following the edge that captured the sample.
- R6: After integ_reset_i is seen, amp_valid_o stays low until 8 + gap_i samples have been accepted. A sample accepted in the same cycle as integ_reset_i counts as the first of them.
- R7: amp_o holds its last value in every cycle in which amp_valid_o is low.
- R8: The result cannot overflow. Four samples of 4095 after four samples of 0 give +16380, and the reverse gives −16380.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 12 | Unsigned ADC sample |
| sample_valid_i | input | 1 | sample_i is accepted this cycle |
| gap_i | input | 3 | Guard gap between windows, in samples |
| integ_reset_i | input | 1 | Integrator has been cleared |
| amp_o | output | 15 | Signed after-minus-before window sum |
| amp_valid_o | output | 1 | amp_o holds a new result |

## Verification
The integrator-reset pulse and an accepted sample can arrive in the same cycle. The two then compete for the fill count: one restarts it and the other advances it. The bench places reset pulses both on cycles that carry a sample and on idle cycles, for every gap setting. It then judges the outcome by the cycle in which the first strobe returns, which must come after exactly 8 + gap accepted samples counted from the reset. It also checks the value of every result against its own arithmetic model.

// File: rtl/cms_pkg.sv
package cms_pkg;
  function automatic int unsigned amp_limit(int unsigned data_w, int unsigned win);
    return win * ((32'd1 << data_w) - 1);
  endfunction
endpackage

// File: rtl/cms_sample_line.sv
module cms_sample_line #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned TAPS   = 15
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [DATA_W-1:0]            sample_i,
  output logic [TAPS-1:0][DATA_W-1:0]  taps_o
);
  logic [TAPS-1:0][DATA_W-1:0] taps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taps_q <= '0;
    end else if (push_i) begin
      taps_q[0] <= sample_i;
      for (int i = 1; i < int'(TAPS); i++) taps_q[i] <= taps_q[i-1];
    end
  end

  assign taps_o = taps_q;
endmodule

// File: rtl/cms_fill_track.sv
module cms_fill_track #(
  parameter int unsigned WIN     = 4,
  parameter int unsigned GAP_MAX = 7,
  parameter int unsigned GAP_W   = 3,
  localparam int unsigned TAPS   = 2*WIN + GAP_MAX,
  localparam int unsigned CNT_W  = $clog2(TAPS+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             restart_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             ready_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= push_i ? CNT_W'(1) : '0;  // sample in the clear cycle is post-clear
    end else if (push_i && cnt_q != CNT_W'(TAPS)) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign ready_o = cnt_q >= (CNT_W'(2*WIN) + CNT_W'(gap_i));
endmodule

// File: rtl/cms_window_sum.sv
module cms_window_sum #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned TAPS   = 15,
  parameter int unsigned WIN    = 4,
  parameter int unsigned OFF_W  = 4,
  parameter int unsigned SUM_W  = 14
) (
  input  logic [TAPS-1:0][DATA_W-1:0] taps_i,
  input  logic [OFF_W-1:0]            off_i,
  output logic [SUM_W-1:0]            sum_o
);
  always_comb begin
    logic [OFF_W-1:0] idx;
    sum_o = '0;
    for (int i = 0; i < int'(WIN); i++) begin
      idx   = off_i + OFF_W'(i);
      sum_o = sum_o + SUM_W'(taps_i[idx]);
    end
  end
endmodule

// File: rtl/cms_charge_extract.sv
module cms_charge_extract #(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned WIN     = 4,
  parameter int unsigned GAP_MAX = 7,
  localparam int unsigned GAP_W  = $clog2(GAP_MAX+1),
  localparam int unsigned OUT_W  = DATA_W + $clog2(WIN) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DATA_W-1:0]       sample_i,
  input  logic                    sample_valid_i,
  input  logic [GAP_W-1:0]        gap_i,
  input  logic                    integ_reset_i,
  output logic signed [OUT_W-1:0] amp_o,
  output logic                    amp_valid_o
);
  localparam int unsigned TAPS  = 2*WIN + GAP_MAX;
  localparam int unsigned OFF_W = $clog2(TAPS);
  localparam int unsigned SUM_W = OUT_W - 1;

  logic [TAPS-1:0][DATA_W-1:0] taps;
  logic [SUM_W-1:0] post_sum, pre_sum, post_q, pre_q;
  logic ready, acc_q, s1_vld_q, vld_q;
  logic signed [OUT_W-1:0] amp_q;

  cms_sample_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(sample_valid_i),
    .sample_i(sample_i), .taps_o(taps));

  cms_fill_track #(.WIN(WIN), .GAP_MAX(GAP_MAX), .GAP_W(GAP_W)) u_fill (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(sample_valid_i),
    .restart_i(integ_reset_i), .gap_i(gap_i), .ready_o(ready));

  cms_window_sum #(.DATA_W(DATA_W), .TAPS(TAPS), .WIN(WIN), .OFF_W(OFF_W), .SUM_W(SUM_W)) u_post (
    .taps_i(taps), .off_i('0), .sum_o(post_sum));

  cms_window_sum #(.DATA_W(DATA_W), .TAPS(TAPS), .WIN(WIN), .OFF_W(OFF_W), .SUM_W(SUM_W)) u_pre (
    .taps_i(taps), .off_i(OFF_W'(WIN) + OFF_W'(gap_i)), .sum_o(pre_sum));

  // stage 1: window sums of the history just updated
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= 1'b0;
      s1_vld_q <= 1'b0;
      post_q   <= '0;
      pre_q    <= '0;
    end else begin
      acc_q    <= sample_valid_i;
      s1_vld_q <= acc_q && ready;
      if (acc_q) begin
        post_q <= post_sum;
        pre_q  <= pre_sum;
      end
    end
  end

  // stage 2: difference, held between strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      amp_q <= '0;
    end else begin
      vld_q <= s1_vld_q;
      if (s1_vld_q) amp_q <= $signed({1'b0, post_q}) - $signed({1'b0, pre_q});
    end
  end

  assign amp_o       = amp_q;
  assign amp_valid_o = vld_q;
endmodule

// File: rtl/cms_charge_extract_chk.sv
module cms_charge_extract_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned WIN    = 4,
  parameter int unsigned OUT_W  = 15
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sample_valid_i,
  input logic                    integ_reset_i,
  input logic signed [OUT_W-1:0] amp_o,
  input logic                    amp_valid_o
);
  localparam int LIM = int'(cms_pkg::amp_limit(DATA_W, WIN));

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!amp_valid_o && amp_o == '0));

  assert_strobe_needs_sample_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_valid_o |-> $past(sample_valid_i, 3));

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_valid_o |-> (int'(amp_o) <= LIM && int'(amp_o) >= -LIM));

  assert_blank_after_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    integ_reset_i |-> ##3 !amp_valid_o);

  assert_hold_between_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !amp_valid_o |=> (amp_valid_o || $stable(amp_o)));
endmodule

bind cms_charge_extract cms_charge_extract_chk #(.DATA_W(DATA_W), .WIN(WIN), .OUT_W(OUT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sample_valid_i(sample_valid_i),
  .integ_reset_i(integ_reset_i), .amp_o(amp_o), .amp_valid_o(amp_valid_o));

// File: tb/cms_charge_extract_tb.sv
module cms_charge_extract_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 4;
  localparam int TAPS = 15;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [11:0] sample_i = '0;
  logic sample_valid_i = 1'b0, integ_reset_i = 1'b0;
  logic [2:0] gap_i = '0;
  logic signed [14:0] amp_o;
  logic amp_valid_o;

  int checks = 0, fails = 0;
  int hist [TAPS];
  int cnt = 0, last_amp = 0;
  bit exp_v [3];
  int exp_a [3];
  string exp_t [3];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cms_charge_extract u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .sample_valid_i(sample_valid_i),
    .gap_i(gap_i), .integ_reset_i(integ_reset_i), .amp_o(amp_o), .amp_valid_o(amp_valid_o));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d gap=%0d", req, act, exp, gap_i);
    end
  endtask

  // one cycle: check outputs due now, update model, drive next inputs
  task automatic step(bit v, bit r, int x);
    int post, pre, g;
    string tag;
    @(negedge clk);
    chk(exp_t[2], int'(amp_valid_o), int'(exp_v[2]));
    if (exp_v[2]) begin
      chk((exp_a[2] == 16380 || exp_a[2] == -16380) ? "R8" : (gap_i != 0 ? "R4" : "R3"),
          int'(amp_o), exp_a[2]);
      last_amp = exp_a[2];
    end else begin
      chk("R7", int'(amp_o), last_amp);
    end
    exp_v[2] = exp_v[1]; exp_a[2] = exp_a[1]; exp_t[2] = exp_t[1];
    exp_v[1] = exp_v[0]; exp_a[1] = exp_a[0]; exp_t[1] = exp_t[0];
    g = int'(gap_i);
    if (r) cnt = v ? 1 : 0;
    else if (v && cnt < TAPS) cnt++;
    if (v) begin
      for (int i = TAPS-1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
    end
    post = 0; pre = 0;
    for (int i = 0; i < WIN; i++) begin
      post += hist[i];
      pre  += hist[WIN+g+i];
    end
    tag = !v ? "R2" : (cnt < 2*WIN+g ? "R6" : "R5");
    exp_v[0] = v && (cnt >= 2*WIN+g);
    exp_a[0] = post - pre;
    exp_t[0] = tag;
    sample_valid_i = v; integ_reset_i = r; sample_i = 12'(x);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin exp_v[i] = 0; exp_a[i] = 0; exp_t[i] = "R2"; end
    for (int i = 0; i < TAPS; i++) hist[i] = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1", int'(amp_valid_o), 0);
      chk("R1", int'(amp_o), 0);
    end
    rst_ni = 1'b1;
    for (int g = 0; g < 8; g++) begin
      for (int i = 0; i < 4; i++) step(0, 0, 0);       // drain before gap change
      @(negedge clk); gap_i = 3'(g);
      step(1, 1, 100 + g);                             // clear with a sample
      for (int k = 0; k < 40; k++) step(($urandom % 4) != 0, 0, int'($urandom % 4096));
      for (int k = 0; k < 12; k++) step(1, 0, 0);
      for (int k = 0; k < 12; k++) step(1, 0, 4095);
      for (int k = 0; k < 12; k++) step(1, 0, 0);
      step(0, 1, 0);                                   // clear on idle cycle
      for (int k = 0; k < 24; k++) step(1, 0, k * 150);
      step(1, 1, 2000);                                // clear with sample mid-stream
      for (int k = 0; k < 20; k++) step((k % 3) != 1, 0, 4095 - k * 97);
    end
    for (int i = 0; i < 4; i++) step(0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule